// File: doc/BRIEF.md
# Indirect Pointer Load Unit

This block executes the indirect byte loads that address data space through the 16-bit Z pointer of a small 8-bit controller. It decodes the instruction word and handles four forms: the pointer left as it is, the pointer bumped up after the access, the pointer stepped down before the access, and an unsigned 6-bit offset added to the pointer. It samples the pointer from a register-file read port and forms the effective address. It then issues one byte read on a synchronous memory port, sends the returned byte to the destination register, and writes the pointer back when the form changes it.

The write of the loaded byte and the pointer writeback leave on separate write ports, so they never contend. A completion pulse tells the sequencer to advance the program counter by one word. A build parameter can restrict pointer arithmetic to the low byte, for a data space of 256 bytes or less. Another can place an 8-bit extension register above Z, which gives 24-bit addressing. No status flag is produced or touched.

Top module: `zload_unit`

## Requirements
- R1: Word pattern `1001000ddddd0001` (post-increment) reads the byte at address Z, writes it to register d, and writes Z+1 back on the pointer port. In the default build the address and the pointer wrap modulo 2^16, so Z=0xFFFF gives a writeback of 0x0000.
- R2: Word pattern `1001000ddddd0010` (pre-decrement) computes Z-1, reads the byte at that address, writes it to register d, and writes Z-1 back on the pointer port, again modulo 2^16.
- R3: Word pattern `10q0qq0ddddd0qqq` reads the byte at Z+q with q unsigned. Here q[5] is word bit 13, q[4:3] are bits 11:10 and q[2:0] are bits 2:0. This form writes no pointer, and the all-zero q case is the plain pointer load.
- R4: The destination index is word bits 8:4, and any value 0..31 is accepted.
- R5: The memory request is high, with its address, in the cycle after acceptance. The byte write, any pointer write and the single-cycle completion pulse come in the cycle after that.
- R6: Busy rises at acceptance and stays high up to and including the completion cycle. Any word presented while busy is high is ignored. Busy reads low after reset.
- R7: A valid word that matches none of the four patterns is not accepted, and busy stays low.
- R8: With the small-data-space parameter set, only the low byte of Z is used. The address is that byte, or that byte plus q, modulo 256, zero-extended. The pointer writeback carries the original high byte unchanged.
- R9: With the extension parameter set, the address and the updated pointer are computed on the 24-bit value {ext, Z}. A pointer-updating form also writes the upper byte to the extension port.
- R10: A post-increment or pre-decrement whose destination is register 30 or 31 raises the illegal flag in its completion cycle. The offset form never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | Instruction word present |
| instr_i | input | 16 | Instruction word |
| zp_i | input | 16 | Z pointer from the register-file read port |
| zx_i | input | 8 | Address extension register |
| busy_o | output | 1 | Instruction in flight |
| mem_req_o | output | 1 | Data-space read request |
| mem_addr_o | output | 24 | Read address, upper bits zero in narrow builds |
| mem_rdata_i | input | 8 | Read data, one cycle after the request |
| rd_we_o | output | 1 | Destination register write enable |
| rd_addr_o | output | 5 | Destination register index |
| rd_data_o | output | 8 | Loaded byte |
| zp_we_o | output | 1 | Pointer write enable (dedicated 16-bit port) |
| zp_wdata_o | output | 16 | Updated pointer |
| zx_we_o | output | 1 | Extension register write enable |
| zx_wdata_o | output | 8 | Updated extension byte |
| done_o | output | 1 | Completion, program counter advances by one |
| illegal_o | output | 1 | Undefined pointer/destination combination |

## Verification
An instruction driven before the edge at which it is accepted shows its memory request and address one cycle later. Its register writes, pointer writeback, illegal flag and completion pulse come one cycle after that. The driver stamps each expected item with the acceptance cycle. The monitor samples on the falling edge and checks the request against that stamp and the completion against the stamp plus one. Three instances, in the default, extended and small-data-space builds, run in lockstep on the same stimulus. Each one's address, byte and writebacks are compared with values the bench computes for that build.

// File: rtl/zload_pkg.sv
package zload_pkg;
  localparam int INSTR_W = 16;
  localparam int REG_AW  = 5;
  localparam int DISP_W  = 6;

  typedef enum logic [1:0] {FORM_POST, FORM_PRE, FORM_DISP} form_e;
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_DONE} st_e;

  typedef struct packed {
    logic              hit;
    form_e             form;
    logic [REG_AW-1:0] rd;
    logic [DISP_W-1:0] q;
    logic              ill;
  } dec_t;
endpackage

// File: rtl/zload_decode.sv
module zload_decode
  import zload_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output dec_t               dec_o
);
  logic is_post, is_pre, is_disp;

  assign is_post = (instr_i[15:9] == 7'b1001000) && (instr_i[3:0] == 4'b0001);
  assign is_pre  = (instr_i[15:9] == 7'b1001000) && (instr_i[3:0] == 4'b0010);
  // offset form: Z select is bit3 low, load is bit9 low
  assign is_disp = (instr_i[15:14] == 2'b10) && !instr_i[12] && !instr_i[9] && !instr_i[3];

  always_comb begin
    dec_o.hit  = is_post | is_pre | is_disp;
    dec_o.form = is_post ? FORM_POST : (is_pre ? FORM_PRE : FORM_DISP);
    dec_o.rd   = instr_i[8:4];
    dec_o.q    = {instr_i[13], instr_i[11:10], instr_i[2:0]};
    dec_o.ill  = (is_post | is_pre) && (&instr_i[8:5]);
  end
endmodule

// File: rtl/zload_agen.sv
module zload_agen
  import zload_pkg::*;
#(
  parameter bit SMALL_DS = 1'b0,
  parameter bit EXT_ADDR = 1'b0,
  parameter int PTR_W    = 16,
  parameter int XW       = 8
) (
  input  form_e                form_i,
  input  logic [PTR_W-1:0]     zp_i,
  input  logic [XW-1:0]        zx_i,
  input  logic [DISP_W-1:0]    q_i,
  output logic [PTR_W+XW-1:0]  addr_o,
  output logic [PTR_W+XW-1:0]  nptr_o
);
  localparam int FW = PTR_W + XW;
  localparam int LW = PTR_W / 2;

  logic unused_zx;
  assign unused_zx = ^zx_i;

  if (SMALL_DS) begin : g_small
    logic [LW-1:0] lo, nlo, alo;
    assign lo = zp_i[LW-1:0];
    always_comb begin
      nlo = lo;
      alo = lo;
      case (form_i)
        FORM_POST: nlo = lo + 1'b1;
        FORM_PRE:  begin nlo = lo - 1'b1; alo = nlo; end
        default:   alo = lo + LW'(q_i);
      endcase
    end
    assign addr_o = FW'(alo);
    assign nptr_o = FW'({zp_i[PTR_W-1:LW], nlo});
  end else begin : g_wide
    localparam int BW = EXT_ADDR ? FW : PTR_W;
    logic [BW-1:0] base, nb, ab;
    if (EXT_ADDR) begin : g_ext
      assign base = {zx_i, zp_i};
    end else begin : g_noext
      assign base = zp_i;
    end
    always_comb begin
      nb = base;
      ab = base;
      case (form_i)
        FORM_POST: nb = base + 1'b1;
        FORM_PRE:  begin nb = base - 1'b1; ab = nb; end
        default:   ab = base + BW'(q_i);
      endcase
    end
    assign addr_o = FW'(ab);
    assign nptr_o = FW'(nb);
  end
endmodule

// File: rtl/zload_unit.sv
module zload_unit
  import zload_pkg::*;
#(
  parameter bit SMALL_DS = 1'b0,
  parameter bit EXT_ADDR = 1'b0,
  parameter int PTR_W    = 16,
  parameter int XW       = 8,
  parameter int DW       = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                instr_valid_i,
  input  logic [INSTR_W-1:0]  instr_i,
  input  logic [PTR_W-1:0]    zp_i,
  input  logic [XW-1:0]       zx_i,
  output logic                busy_o,
  output logic                mem_req_o,
  output logic [PTR_W+XW-1:0] mem_addr_o,
  input  logic [DW-1:0]       mem_rdata_i,
  output logic                rd_we_o,
  output logic [REG_AW-1:0]   rd_addr_o,
  output logic [DW-1:0]       rd_data_o,
  output logic                zp_we_o,
  output logic [PTR_W-1:0]    zp_wdata_o,
  output logic                zx_we_o,
  output logic [XW-1:0]       zx_wdata_o,
  output logic                done_o,
  output logic                illegal_o
);
  localparam int FW     = PTR_W + XW;
  localparam bit EXT_WB = EXT_ADDR && !SMALL_DS;

  dec_t            dec;
  logic [FW-1:0]   addr_d, nptr_d;
  st_e             st_q;
  logic [FW-1:0]   addr_q, nptr_q;
  logic [REG_AW-1:0] rd_q;
  logic            wb_q, ill_q;
  logic            accept;

  zload_decode u_dec (
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  zload_agen #(
    .SMALL_DS (SMALL_DS),
    .EXT_ADDR (EXT_ADDR),
    .PTR_W    (PTR_W),
    .XW       (XW)
  ) u_agen (
    .form_i (dec.form),
    .zp_i   (zp_i),
    .zx_i   (zx_i),
    .q_i    (dec.q),
    .addr_o (addr_d),
    .nptr_o (nptr_d)
  );

  assign accept = instr_valid_i && dec.hit && (st_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      nptr_q <= '0;
      rd_q   <= '0;
      wb_q   <= 1'b0;
      ill_q  <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (accept) begin
          st_q   <= ST_ISSUE;
          addr_q <= addr_d;
          nptr_q <= nptr_d;
          rd_q   <= dec.rd;
          wb_q   <= (dec.form != FORM_DISP);
          ill_q  <= dec.ill;
        end
        ST_ISSUE: st_q <= ST_DONE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (st_q != ST_IDLE);
  assign mem_req_o  = (st_q == ST_ISSUE);
  assign mem_addr_o = addr_q;
  assign done_o     = (st_q == ST_DONE);
  assign rd_we_o    = done_o;
  assign rd_addr_o  = rd_q;
  assign rd_data_o  = mem_rdata_i;
  assign zp_we_o    = done_o && wb_q;
  assign zp_wdata_o = nptr_q[PTR_W-1:0];
  assign zx_we_o    = done_o && wb_q && EXT_WB;
  assign zx_wdata_o = nptr_q[FW-1:PTR_W];
  assign illegal_o  = done_o && ill_q;
endmodule

// File: rtl/zload_unit_sva.sv
module zload_unit_sva (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       instr_valid_i,
  input logic       busy_o,
  input logic       mem_req_o,
  input logic       done_o,
  input logic       rd_we_o,
  input logic [4:0] rd_addr_o,
  input logic       zp_we_o,
  input logic       zx_we_o,
  input logic       illegal_o
);
  assert_req_then_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> (done_o && !mem_req_o));
  assert_done_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_start_issue_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> mem_req_o);
  assert_busy_span_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);
  assert_busy_cover_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || mem_req_o) |-> busy_o);
  assert_idle_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !instr_valid_i) |=> !busy_o);
  assert_zwb_with_data_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zp_we_o |-> rd_we_o);
  assert_ext_with_ptr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zx_we_o |-> zp_we_o);
  assert_illegal_dest_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (zp_we_o && rd_addr_o[4:1] == 4'b1111));
endmodule

bind zload_unit zload_unit_sva u_sva (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .instr_valid_i (instr_valid_i),
  .busy_o        (busy_o),
  .mem_req_o     (mem_req_o),
  .done_o        (done_o),
  .rd_we_o       (rd_we_o),
  .rd_addr_o     (rd_addr_o),
  .zp_we_o       (zp_we_o),
  .zx_we_o       (zx_we_o),
  .illegal_o     (illegal_o)
);

// File: tb/zload_unit_test.sv
module zload_unit_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic iv;
  logic [15:0] ins, zp;
  logic [7:0]  xr;
  logic        busy[3], req[3], done[3], rwe[3], zwe[3], ewe[3], ill[3];
  logic [23:0] maddr[3], la[3];
  logic [7:0]  mrd[3], rdat[3], ewd[3];
  logic [4:0]  rda[3];
  logic [15:0] zwd[3];
  int cyc = 0, n_run = 0, n_fail = 0;

  typedef struct packed {
    logic [4:0]        rd;
    logic              ill;
    logic              wb;
    logic [31:0]       acc;
    logic [2:0][23:0]  addr;
    logic [2:0][15:0]  zwd;
    logic [7:0]        ewd;
  } exp_t;
  exp_t  q_exp[$];
  string q_tag[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  zload_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .instr_valid_i(iv), .instr_i(ins), .zp_i(zp), .zx_i(xr),
    .busy_o(busy[0]), .mem_req_o(req[0]), .mem_addr_o(maddr[0]), .mem_rdata_i(mrd[0]),
    .rd_we_o(rwe[0]), .rd_addr_o(rda[0]), .rd_data_o(rdat[0]), .zp_we_o(zwe[0]),
    .zp_wdata_o(zwd[0]), .zx_we_o(ewe[0]), .zx_wdata_o(ewd[0]), .done_o(done[0]),
    .illegal_o(ill[0]));
  zload_unit #(.EXT_ADDR(1'b1)) uut_ext (
    .clk_i(clk), .rst_ni(rst_n), .instr_valid_i(iv), .instr_i(ins), .zp_i(zp), .zx_i(xr),
    .busy_o(busy[1]), .mem_req_o(req[1]), .mem_addr_o(maddr[1]), .mem_rdata_i(mrd[1]),
    .rd_we_o(rwe[1]), .rd_addr_o(rda[1]), .rd_data_o(rdat[1]), .zp_we_o(zwe[1]),
    .zp_wdata_o(zwd[1]), .zx_we_o(ewe[1]), .zx_wdata_o(ewd[1]), .done_o(done[1]),
    .illegal_o(ill[1]));
  zload_unit #(.SMALL_DS(1'b1)) uut_small (
    .clk_i(clk), .rst_ni(rst_n), .instr_valid_i(iv), .instr_i(ins), .zp_i(zp), .zx_i(xr),
    .busy_o(busy[2]), .mem_req_o(req[2]), .mem_addr_o(maddr[2]), .mem_rdata_i(mrd[2]),
    .rd_we_o(rwe[2]), .rd_addr_o(rda[2]), .rd_data_o(rdat[2]), .zp_we_o(zwe[2]),
    .zp_wdata_o(zwd[2]), .zx_we_o(ewe[2]), .zx_wdata_o(ewd[2]), .done_o(done[2]),
    .illegal_o(ill[2]));

  function automatic logic [7:0] mfn(logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
  endfunction

  // synchronous data-space model
  always @(posedge clk) begin
    for (int k = 0; k < 3; k++) if (req[k]) mrd[k] <= mfn(maddr[k]);
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic report;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      for (int k = 0; k < 3; k++) if (req[k]) la[k] = maddr[k];
      if (req[0] && q_exp.size() > 0) chk("R5 req cycle", cyc, q_exp[0].acc);
      if (done[0]) begin
        if (q_exp.size() == 0) chk("R6 unexpected completion", 1, 0);
        else begin
          exp_t e;
          string t;
          e = q_exp.pop_front();
          t = q_tag.pop_front();
          chk("R5 done cycle", cyc, e.acc + 1);
          for (int k = 0; k < 3; k++) begin
            string tk;
            tk = (k == 2) ? "R8" : ((k == 1) ? "R9" : t);
            chk("R5 lockstep done", done[k], 1);
            chk({tk, " addr"}, la[k], e.addr[k]);
            chk({tk, " data"}, rdat[k], mfn(e.addr[k]));
            chk("R4 dest", rda[k], e.rd);
            chk({tk, " zp_we"}, zwe[k], e.wb);
            if (e.wb) chk({tk, " zp_wdata"}, zwd[k], e.zwd[k]);
            chk("R9 zx_we", ewe[k], (k == 1) && e.wb);
            if (k == 1 && e.wb) chk("R9 zx_wdata", ewd[k], e.ewd);
            chk("R10 illegal", ill[k], e.ill);
          end
        end
      end
      for (int k = 0; k < 3; k++)
        if (!done[k] && (rwe[k] || zwe[k] || ewe[k])) chk("R5 write outside completion", 1, 0);
    end
  end

  task automatic go(input int f, input logic [4:0] d, input logic [5:0] q,
                    input logic [15:0] z, input logic [7:0] x);
    logic [15:0] op, n16, a16;
    logic [23:0] f24, n24, a24;
    logic [7:0]  n8, a8;
    exp_t e;
    f24 = {x, z};
    case (f)
      0: begin op = {7'b1001000, d, 4'b0001}; n16 = z + 1; a16 = z; n24 = f24 + 1; a24 = f24;
               n8 = z[7:0] + 1; a8 = z[7:0]; end
      1: begin op = {7'b1001000, d, 4'b0010}; n16 = z - 1; a16 = n16; n24 = f24 - 1; a24 = n24;
               n8 = z[7:0] - 1; a8 = n8; end
      default: begin op = {2'b10, q[5], 1'b0, q[4:3], 1'b0, d, 1'b0, q[2:0]};
               n16 = z; a16 = z + q; n24 = f24; a24 = f24 + q; n8 = z[7:0]; a8 = z[7:0] + q; end
    endcase
    while (busy[0]) @(negedge clk);
    e.rd = d; e.wb = (f != 2); e.ill = (f != 2) && (d >= 5'd30);
    e.addr[0] = {8'h00, a16}; e.addr[1] = a24; e.addr[2] = {16'h0000, a8};
    e.zwd[0] = n16; e.zwd[1] = n24[15:0]; e.zwd[2] = {z[15:8], n8};
    e.ewd = n24[23:16];
    e.acc = cyc + 1;
    q_exp.push_back(e);
    q_tag.push_back(f == 0 ? "R1" : (f == 1 ? "R2" : "R3"));
    iv = 1'b1; ins = op; zp = z; xr = x;
    @(negedge clk);
    iv = 1'b0; zp = ~z; xr = ~x;  // pointer must have been captured
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk("watchdog expired", 1, 0);
    report();
    $finish;
  end

  initial begin
    iv = 1'b0; ins = '0; zp = '0; xr = '0;
    repeat (3) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      chk("R6 reset busy", busy[k], 0);
      chk("R5 reset req", req[k], 0);
      chk("R5 reset done", done[k], 0);
    end
    rst_n = 1'b1;
    @(negedge clk);

    go(0, 5'd5, 6'd0, 16'h1234, 8'h07);
    go(1, 5'd17, 6'd0, 16'h1234, 8'h07);
    go(2, 5'd31, 6'h3F, 16'h12F0, 8'h21);
    go(2, 5'd0, 6'h00, 16'hABCD, 8'h00);
    go(2, 5'd12, 6'h20, 16'h0100, 8'h00);
    go(2, 5'd7, 6'h18, 16'h0100, 8'h00);
    go(2, 5'd2, 6'h05, 16'hFFFE, 8'h44);
    go(0, 5'd1, 6'd0, 16'hFFFF, 8'h12);
    go(1, 5'd8, 6'd0, 16'h0000, 8'h01);
    go(1, 5'd20, 6'd0, 16'h5600, 8'h00);
    go(0, 5'd30, 6'd0, 16'h0200, 8'h00);
    go(1, 5'd31, 6'd0, 16'h0200, 8'h00);
    go(0, 5'd29, 6'd0, 16'h0300, 8'h00);
    go(2, 5'd30, 6'h01, 16'h0300, 8'h00);

    // R7: non-matching words are not accepted
    while (busy[0]) @(negedge clk);
    iv = 1'b1;
    ins = 16'h800C; @(negedge clk); chk("R7 pointer-select bit set", busy[0], 0);
    ins = 16'h900F; @(negedge clk); chk("R7 unknown mode", busy[0], 0);
    ins = 16'h8200; @(negedge clk); chk("R7 store bit set", busy[0], 0);
    iv = 1'b0;

    // R6: words offered while busy are dropped
    go(0, 5'd3, 6'd0, 16'h4000, 8'h00);
    iv = 1'b1; ins = {7'b1001000, 5'd9, 4'b0001}; zp = 16'h7777;
    chk("R6 busy at issue", busy[0], 1);
    @(negedge clk);
    chk("R6 busy at completion", busy[0], 1);
    @(negedge clk);
    iv = 1'b0;
    repeat (3) @(negedge clk);
    chk("R6 ignored word not started", busy[0], 0);
    chk("R6 nothing pending", q_exp.size(), 0);

    go(1, 5'd4, 6'd0, 16'h8000, 8'hFF);
    while (q_exp.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    report();
    $finish;
  end
endmodule